// File: doc/BRIEF.md
# Run-Time Configurable Serial Frame Transmitter

This block takes bytes from a 16-entry transmit queue and sends them one at a time on a single serial output. Software sets the frame shape at run time by writing one control byte. The byte selects the character length (5 to 8 bits), whether a parity bit is added and whether that parity is even or odd, and whether one or two stop bits follow. A frame is a low start bit, then the data bits least significant first, then the optional parity bit, then the high stop bits. Each bit lasts one period of an external baud enable pulse, and the line rests high between frames. Frames go out back to back whenever the queue holds data.

The same control byte holds three line-management switches. The first turns on hardware flow control, so that no new frame starts while the clear-to-send input is low. The second requests a break: once the frame in progress ends, the line is driven low and held there. The third is a level-held flush: while it is set, the serialiser is forced idle and the queue is kept empty. It stays in force until software writes it back to zero.

Top module: `utx_frame_top`

## Requirements
- R1: After reset the control register reads 0x18, `tx` is high, `fifo_empty` is 1 and `fifo_full` is 0.
- R2: A frame is one low start bit, then the data bits with bit 0 first, then the optional parity bit, then the stop bits at 1. Each bit occupies one `baud_tick` interval. After the last stop bit the line returns high, or the next frame's start bit follows at once if the queue is not empty.
- R3: Control bits [4:3] set the data length: 2'b00 selects 5 bits, 2'b01 selects 6, 2'b10 selects 7 and 2'b11 selects 8. Byte bits above the length are not sent.
- R4: Control bit 2 set adds one parity bit after the data. Control bit 1 = 0 makes the parity bit the XOR of the sent data bits (even parity). Control bit 1 = 1 makes it the inverse of that XOR (odd parity).
- R5: Control bit 0 = 0 sends one stop bit and control bit 0 = 1 sends two.
- R6: The frame format is captured when a frame starts. A control write during a frame does not change that frame.
- R7: A write to the control register is returned unchanged on `reg_rdata` from the next cycle.
- R8: The queue holds 16 bytes and sends them in push order. `fifo_full` is 1 when 16 bytes are held. A push while the queue is full is dropped.
- R9: With control bit 5 = 1, no frame starts while `cts` is low. With bit 5 = 0, `cts` is ignored.
- R10: With control bit 6 = 1, a frame already in progress completes. After that `tx` is held low and no new frame starts until bit 6 is cleared.
- R11: One clock after control bit 7 becomes 1, the transmitter is idle with `tx` high and the queue is empty. Pushes are dropped while bit 7 stays 1.
- R12: Bit 7 stays set until software writes it to 0. After it is cleared, the queue remains empty and the line remains idle until new bytes are pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| push_valid | input | 1 | Push one byte into the transmit queue |
| push_data | input | 8 | Byte to push |
| fifo_full | output | 1 | Transmit queue holds 16 bytes |
| fifo_empty | output | 1 | Transmit queue holds no bytes |
| baud_tick | input | 1 | One-clock pulse marking each bit period |
| cts | input | 1 | Clear to send from the far end, high means send allowed |
| tx | output | 1 | Serial transmit line, registered |

## Verification
On every cycle the assertions check the following:
- the queue never holds more than its depth, and a full queue stays full when a push is refused;
- stop bits are high;
- the captured format stays stable through the data bits;
- an idle transmitter held back by flow control or break does not start a frame, and break drives the line low;
- a set flush bit leaves the queue empty and the line high one clock later.

The following can only be shown by the bench's directed scenarios, which decode the line after each baud tick:
- the exact bit order and parity value for each length, parity and stop setting;
- that a mid-frame control write does not change the frame;
- push ordering and the dropped seventeenth byte;
- that break is deferred until the frame ends;
- that the flush bit persists until it is cleared.

// File: rtl/utx_pkg.sv
package utx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } tx_state_t;

  // Control byte layout, most significant field first.
  typedef struct packed {
    logic       flush;     // bit 7
    logic       brk;       // bit 6
    logic       flow_en;   // bit 5
    logic [1:0] len_sel;   // bits 4:3
    logic       par_en;    // bit 2
    logic       par_odd;   // bit 1
    logic       two_stop;  // bit 0
  } ctrl_t;

  localparam logic [7:0] CTRL_RESET = 8'h18;

endpackage

// File: rtl/utx_ctrl_reg.sv
module utx_ctrl_reg #(
  parameter int              W         = 8,
  parameter logic [W-1:0]    RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= RESET_VAL;
    else if (we) q <= wdata;
  end

endmodule

// File: rtl/utx_sync.sv
module utx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= RST_VAL;
          else     chain_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= RST_VAL;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/utx_fifo.sv
module utx_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              full,
  output logic              empty
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
  logic [AW:0]       count_q;
  logic              do_push, do_pop;

  assign full    = (count_q == (AW+1)'(DEPTH));
  assign empty   = (count_q == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;

  // Storage has no reset so that it maps onto a RAM primitive.
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= push_data;
  end

  assign head = mem[rd_ptr_q];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == AW'(DEPTH-1)) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == AW'(DEPTH-1)) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  // R8: occupancy never exceeds the depth
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    count_q <= (AW+1)'(DEPTH));

  // R8: a refused push leaves the queue full
  p_drop_when_full_r8: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !clr) |=> full);

endmodule

// File: rtl/utx_serializer.sv
module utx_serializer #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              brk,
  input  logic              flow_en,
  input  logic              cts_ok,
  input  logic [1:0]        len_sel,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              two_stop,
  input  logic              baud_tick,
  input  logic              q_empty,
  input  logic [DATA_W-1:0] q_head,
  output logic              q_pop,
  output logic              tx
);
  import utx_pkg::*;

  tx_state_t         state_q;
  logic [DATA_W-1:0] shift_q;
  logic [CNT_W-1:0]  bit_cnt_q, len_m1_q;
  logic              stop_cnt_q;
  logic              par_en_q, par_bit_q, two_stop_q;
  logic              tx_q;

  logic [DATA_W-1:0] len_mask;
  logic [CNT_W-1:0]  len_m1;
  logic              can_start, last_stop, start_now, par_calc;

  // Length 5..8: mask the head byte and compute parity over the sent bits.
  assign len_m1   = CNT_W'(4) + CNT_W'(len_sel);
  assign len_mask = {DATA_W{1'b1}} >> (2'd3 - len_sel);
  assign par_calc = (^(q_head & len_mask)) ^ par_odd;

  assign can_start = !q_empty && !brk && (!flow_en || cts_ok);
  assign last_stop = (stop_cnt_q == two_stop_q);
  assign start_now = baud_tick && can_start && !flush &&
                     ((state_q == ST_IDLE) || (state_q == ST_STOP && last_stop));
  assign q_pop     = start_now;
  assign tx        = tx_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      state_q    <= ST_IDLE;
      tx_q       <= 1'b1;
      shift_q    <= '0;
      bit_cnt_q  <= '0;
      stop_cnt_q <= 1'b0;
      len_m1_q   <= '0;
      par_en_q   <= 1'b0;
      par_bit_q  <= 1'b0;
      two_stop_q <= 1'b0;
    end else if (start_now) begin
      state_q    <= ST_START;
      tx_q       <= 1'b0;
      shift_q    <= q_head;
      len_m1_q   <= len_m1;
      par_en_q   <= par_en;
      par_bit_q  <= par_calc;
      two_stop_q <= two_stop;
    end else begin
      case (state_q)
        ST_IDLE: tx_q <= !brk;
        ST_START: if (baud_tick) begin
          state_q   <= ST_DATA;
          tx_q      <= shift_q[0];
          shift_q   <= shift_q >> 1;
          bit_cnt_q <= '0;
        end
        ST_DATA: if (baud_tick) begin
          if (bit_cnt_q == len_m1_q) begin
            stop_cnt_q <= 1'b0;
            if (par_en_q) begin
              state_q <= ST_PARITY;
              tx_q    <= par_bit_q;
            end else begin
              state_q <= ST_STOP;
              tx_q    <= 1'b1;
            end
          end else begin
            tx_q      <= shift_q[0];
            shift_q   <= shift_q >> 1;
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end
        end
        ST_PARITY: if (baud_tick) begin
          state_q    <= ST_STOP;
          tx_q       <= 1'b1;
          stop_cnt_q <= 1'b0;
        end
        ST_STOP: if (baud_tick) begin
          if (last_stop) begin
            state_q <= ST_IDLE;
            tx_q    <= !brk;
          end else begin
            stop_cnt_q <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: stop bits are always high on the line
  p_stop_high_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STOP) |-> tx_q);

  // R6: the captured length does not move during the data bits
  p_fmt_held_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DATA) |=> (state_q != ST_DATA || $stable(len_m1_q)));

  // R9: an idle transmitter held by flow control stays idle
  p_cts_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && flow_en && !cts_ok) |=> (state_q == ST_IDLE));

  // R10: break on an idle transmitter drives the line low
  p_break_low_r10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && brk && !flush) |=> (!tx_q && state_q == ST_IDLE));

endmodule

// File: rtl/utx_frame_top.sv
module utx_frame_top #(
  parameter int FIFO_DEPTH = 16,
  parameter int DATA_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  output logic              fifo_full,
  output logic              fifo_empty,
  input  logic              baud_tick,
  input  logic              cts,
  output logic              tx
);
  import utx_pkg::*;

  logic [7:0]        ctrl_raw;
  ctrl_t             ctrl;
  logic              cts_ok, q_pop;
  logic [DATA_W-1:0] q_head;

  utx_ctrl_reg #(.W(8), .RESET_VAL(CTRL_RESET)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .we    (reg_we),
    .wdata (reg_wdata),
    .q     (ctrl_raw)
  );

  assign ctrl      = ctrl_t'(ctrl_raw);
  assign reg_rdata = ctrl_raw;

  utx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_cts_sync (
    .clk (clk),
    .rst (rst),
    .d   (cts),
    .q   (cts_ok)
  );

  utx_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .clr       (ctrl.flush),
    .push      (push_valid),
    .push_data (push_data),
    .pop       (q_pop),
    .head      (q_head),
    .full      (fifo_full),
    .empty     (fifo_empty)
  );

  utx_serializer #(.DATA_W(DATA_W)) u_ser (
    .clk       (clk),
    .rst       (rst),
    .flush     (ctrl.flush),
    .brk       (ctrl.brk),
    .flow_en   (ctrl.flow_en),
    .cts_ok    (cts_ok),
    .len_sel   (ctrl.len_sel),
    .par_en    (ctrl.par_en),
    .par_odd   (ctrl.par_odd),
    .two_stop  (ctrl.two_stop),
    .baud_tick (baud_tick),
    .q_empty   (fifo_empty),
    .q_head    (q_head),
    .q_pop     (q_pop),
    .tx        (tx)
  );

  // R11: one clock after flush is seen, queue empty and line high
  p_flush_clears_r11: assert property (@(posedge clk) disable iff (rst)
    ctrl.flush |=> (fifo_empty && tx));

  // R7: register write is returned on the read port next cycle
  p_readback_r7: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> (reg_rdata == $past(reg_wdata)));

endmodule

// File: tb/tb_utx_frame_top.sv
module tb_utx_frame_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       push_valid = 1'b0;
  logic [7:0] push_data = '0;
  logic       fifo_full, fifo_empty;
  logic       baud_tick = 1'b0;
  logic       cts = 1'b1;
  logic       tx;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  utx_frame_top dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .push_valid(push_valid), .push_data(push_data),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .baud_tick(baud_tick),
    .cts(cts), .tx(tx)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk); reg_we = 1'b1; reg_wdata = v;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic push(input logic [7:0] v);
    @(negedge clk); push_valid = 1'b1; push_data = v;
    @(negedge clk); push_valid = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); baud_tick = 1'b1;
    @(negedge clk); baud_tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Ticks through one frame and checks every bit; skip_start means the
  // caller already ticked and checked the start bit.
  task automatic send_frame_check(input logic [7:0] d, input logic [7:0] cfg,
                                  input bit skip_start, input string tag);
    int len = int'(cfg[4:3]) + 5;
    logic p = cfg[1];
    if (!skip_start) begin
      tick(); check(tx, 1'b0, {tag, " start bit R2"});
    end
    for (int i = 0; i < len; i++) begin
      tick(); check(tx, d[i], $sformatf("%s data bit %0d R2 R3", tag, i));
      p = p ^ d[i];
    end
    if (cfg[2]) begin
      tick(); check(tx, p, {tag, " parity bit R4"});
    end
    for (int s = 0; s < (cfg[0] ? 2 : 1); s++) begin
      tick(); check(tx, 1'b1, $sformatf("%s stop bit %0d R5", tag, s));
    end
  endtask

  task automatic t_reset();
    check(reg_rdata, 8'h18, "R1 reset control value");
    check(tx, 1'b1, "R1 idle line");
    check(fifo_empty, 1'b1, "R1 empty");
    check(fifo_full, 1'b0, "R1 not full");
  endtask

  task automatic t_formats();
    push(8'hA5); send_frame_check(8'hA5, 8'h18, 0, "8N1");
    tick(); check(tx, 1'b1, "R2 line returns high");
    wr_ctrl(8'h05);
    push(8'hF3); send_frame_check(8'hF3, 8'h05, 0, "5E2 R3 R5");
    tick(); check(tx, 1'b1, "R2 idle after 5E2");
    wr_ctrl(8'h16);
    push(8'h6B); send_frame_check(8'h6B, 8'h16, 0, "7O1 R4");
    wr_ctrl(8'h08);
    push(8'h2C); send_frame_check(8'h2C, 8'h08, 0, "6N1 R3");
    tick(); check(tx, 1'b1, "R2 idle after 6N1");
  endtask

  task automatic t_latch();
    wr_ctrl(8'h18);
    push(8'h9E);
    tick(); check(tx, 1'b0, "R6 start");
    wr_ctrl(8'h05);
    send_frame_check(8'h9E, 8'h18, 1, "R6 frame keeps captured format");
    tick(); check(tx, 1'b1, "R6 idle after");
    wr_ctrl(8'h18);
  endtask

  task automatic t_readback();
    wr_ctrl(8'h2C); check(reg_rdata, 8'h2C, "R7 readback 2C");
    wr_ctrl(8'h13); check(reg_rdata, 8'h13, "R7 readback 13");
    wr_ctrl(8'h18);
  endtask

  task automatic t_full();
    for (int i = 0; i < 16; i++) push(8'h30 + 8'(i));
    check(fifo_full, 1'b1, "R8 full at 16");
    push(8'hEE);
    check(fifo_full, 1'b1, "R8 still full after extra push");
    for (int i = 0; i < 16; i++)
      send_frame_check(8'h30 + 8'(i), 8'h18, 0, $sformatf("R8 entry %0d", i));
    tick(); check(tx, 1'b1, "R8 dropped byte not sent");
    check(fifo_empty, 1'b1, "R8 empty after 16");
  endtask

  task automatic t_flow();
    wr_ctrl(8'h38); cts = 1'b0; repeat (4) @(negedge clk);
    push(8'h77);
    for (int i = 0; i < 3; i++) begin
      tick(); check(tx, 1'b1, "R9 held by cts");
    end
    check(fifo_empty, 1'b0, "R9 byte still queued");
    cts = 1'b1; repeat (4) @(negedge clk);
    send_frame_check(8'h77, 8'h38, 0, "R9 after cts");
    tick();
    wr_ctrl(8'h18); cts = 1'b0; repeat (4) @(negedge clk);
    push(8'h21); send_frame_check(8'h21, 8'h18, 0, "R9 cts ignored when off");
    tick(); cts = 1'b1;
  endtask

  task automatic t_break();
    push(8'h5A); push(8'hC3);
    tick(); check(tx, 1'b0, "R10 start before break");
    wr_ctrl(8'h58);
    send_frame_check(8'h5A, 8'h18, 1, "R10 frame completes");
    tick(); check(tx, 1'b0, "R10 break low after frame");
    tick(); check(tx, 1'b0, "R10 break held");
    check(fifo_empty, 1'b0, "R10 next byte not started");
    wr_ctrl(8'h18); @(negedge clk);
    check(tx, 1'b1, "R10 line high after break cleared");
    send_frame_check(8'hC3, 8'h18, 0, "R10 queued byte after break");
    tick();
  endtask

  task automatic t_flush();
    push(8'h11); push(8'h22); push(8'h33);
    tick(); tick();
    wr_ctrl(8'h98); @(negedge clk);
    check(tx, 1'b1, "R11 line idle one clock after flush");
    check(fifo_empty, 1'b1, "R11 queue emptied");
    push(8'h44);
    check(fifo_empty, 1'b1, "R11 push dropped during flush");
    tick(); check(tx, 1'b1, "R11 no frame during flush");
    check(reg_rdata, 8'h98, "R12 flush bit sticky");
    wr_ctrl(8'h18);
    check(fifo_empty, 1'b1, "R12 still empty after clear");
    tick(); tick(); check(tx, 1'b1, "R12 stays idle after clear");
    push(8'h6D); send_frame_check(8'h6D, 8'h18, 0, "R12 normal after clear");
    tick();
  endtask

  initial begin : watchdog
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_formats();
    t_latch();
    t_readback();
    t_full();
    t_flow();
    t_break();
    t_flush();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule